// File: doc/BRIEF.md
# Carry-Save Montgomery Multiplier

This block computes a Montgomery product one multiplier bit per clock. The multiplier A and the multiplicand B each arrive as a pair of binary vectors whose sum is the operand. The running accumulator is also kept as a pair. It is never resolved to binary while the loop runs. In each iteration the block takes the next bit of A1 + A2 and derives a parity bit q from the low bits of the accumulator and the selected multiplicand. It then reduces five vectors to two: both accumulator halves, both gated multiplicand halves and the gated modulus. Last, it halves the result with a one-bit right shift.

The datapath is cut into fixed-width carry-save slices. Carries between layers ripple only from one slice into its neighbour. The serial multiplier bit and q are each formed once and fed to every slice, so all slices use the same pair of bits in a given cycle. A start pulse captures all operands and clears the accumulator. After a fixed number of iterations the block raises done for one cycle. The redundant result pair then stays on the outputs until the next start. A later stage does the final subtraction and the conversion to binary.

Top module: `csa_mont_mul`

## Requirements
- R1: In the cycle after start is sampled, both result outputs are zero.
- R2: done goes high exactly ITERS clock edges after the edge that samples start, and it stays high for exactly one cycle.
- R3: At done, sum1 + sum2 equals the result of this exact recurrence. S starts at 0. For i from 0 to ITERS-1, a = bit i of (A1 + A2) and T = S + a·(B1 + B2). If T is odd, add M to T. Then S = T/2. As a result, (sum1 + sum2)·2^ITERS ≡ (A1 + A2)·(B1 + B2) mod M.
- R4: The multiplier bit stream is the binary sum A1 + A2, formed serially with a carry, and that includes the final carry out of the top bit (e.g. A1 = A2 = all ones).
- R5: A1, A2, B1, B2 and M are captured when start is sampled. Changes on those inputs while the run is in progress do not affect the result.
- R6: A start pulse during a run is ignored. The run ends on time with the result of the first start.
- R7: When B1 + B2 < M and M is odd, the final sum1 + sum2 is below 2M.
- R8: After done, sum1 and sum2 hold their values until the next start, whatever the operand inputs do.
- R9: A zero multiplier (A1 = A2 = 0) or a zero multiplicand (B1 = B2 = 0) gives sum1 + sum2 = 0.
- R10: The internal vectors are two guard bits plus one headroom bit wider than M. No carry is ever lost out of the top slice, and no set bit is ever dropped by the halving shift.
- R11: While reset is held, and after it is released with no start yet, done is low and both result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a multiplication when the block is idle |
| a1 | input | WIDTH | Multiplier, first half of the pair |
| a2 | input | WIDTH | Multiplier, second half of the pair |
| b1 | input | WIDTH | Multiplicand, first half of the pair |
| b2 | input | WIDTH | Multiplicand, second half of the pair |
| modulus | input | WIDTH | Odd modulus M |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum1 | output | WIDTH+2 | Result, first carry-save half |
| sum2 | output | WIDTH+2 | Result, second carry-save half |

## Verification
The hardest situation to reach is a carry crossing the slice boundary in all three compression layers in the same cycle, together with a serial carry in the A adder that lasts right to the final extra iteration. Random operands seldom line up that way. Directed cases therefore use all-ones halves of A and B against a modulus with its top bit set, which keeps high bits busy in every slice and forces the final carry out of A1 + A2. Random runs also scramble every operand input and inject a stray start in the middle of a run, so the capture and ignore rules are exercised against the exact recurrence.

// File: rtl/csa_mm_pkg.sv
package csa_mm_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // perform one iteration
  } mmStrobeT;

endpackage

// File: rtl/csa_mm_slice.sv
// One carry-save slice: three stacked 3:2 layers reduce five vectors to two.
// Each layer's shifted-out carry is passed to the next slice up.
module csa_mm_slice #(
  parameter int SW = 64
) (
  input  logic [SW-1:0] s1,
  input  logic [SW-1:0] s2,
  input  logic [SW-1:0] p1,
  input  logic [SW-1:0] p2,
  input  logic [SW-1:0] qm,
  input  logic [2:0]    cin,
  output logic [SW-1:0] sumV,
  output logic [SW-1:0] carV,
  output logic [2:0]    cout
);

  logic [SW-1:0] x1, k1, k1Sh;
  logic [SW-1:0] x2, k2, k2Sh;
  logic [SW-1:0] x3, k3;

  always_comb begin
    // layer 1: accumulator halves plus first multiplicand half
    x1   = s1 ^ s2 ^ p1;
    k1   = (s1 & s2) | (s1 & p1) | (s2 & p1);
    k1Sh = {k1[SW-2:0], cin[0]};
    // layer 2: partial sum plus second multiplicand half and modulus
    x2   = x1 ^ p2 ^ qm;
    k2   = (x1 & p2) | (x1 & qm) | (p2 & qm);
    k2Sh = {k2[SW-2:0], cin[1]};
    // layer 3: fold both carry vectors back in
    x3   = x2 ^ k1Sh ^ k2Sh;
    k3   = (x2 & k1Sh) | (x2 & k2Sh) | (k1Sh & k2Sh);
    sumV = x3;
    carV = {k3[SW-2:0], cin[2]};
    cout = {k3[SW-1], k2[SW-1], k1[SW-1]};
  end

endmodule

// File: rtl/csa_mm_aser.sv
// Serial adder that turns the multiplier pair into one bit per iteration.
module csa_mm_aser #(
  parameter int WIDTH = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  csa_mm_pkg::mmStrobeT  strobe,
  input  logic [WIDTH-1:0]      a1,
  input  logic [WIDTH-1:0]      a2,
  output logic                  aBit
);

  logic [WIDTH-1:0] shA1, shA2;
  logic             carryQ;

  assign aBit = shA1[0] ^ shA2[0] ^ carryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shA1   <= '0;
      shA2   <= '0;
      carryQ <= 1'b0;
    end else if (strobe.load) begin
      shA1   <= a1;
      shA2   <= a2;
      carryQ <= 1'b0;
    end else if (strobe.step) begin
      shA1   <= {1'b0, shA1[WIDTH-1:1]};
      shA2   <= {1'b0, shA2[WIDTH-1:1]};
      carryQ <= (shA1[0] & shA2[0]) | (shA1[0] & carryQ) | (shA2[0] & carryQ);
    end
  end

endmodule

// File: rtl/csa_mm_dp.sv
// Datapath: operand capture, broadcast bits, sliced compressor, shifted accumulator.
module csa_mm_dp #(
  parameter int WIDTH  = 128,
  parameter int SLICE  = 64,
  parameter int NSLICE = 3,
  parameter int EXT    = 130
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  csa_mm_pkg::mmStrobeT  strobe,
  input  logic [WIDTH-1:0]      a1,
  input  logic [WIDTH-1:0]      a2,
  input  logic [WIDTH-1:0]      b1,
  input  logic [WIDTH-1:0]      b2,
  input  logic [WIDTH-1:0]      modulus,
  output logic [EXT-1:0]        sum1,
  output logic [EXT-1:0]        sum2,
  output logic                  lostBits
);

  localparam int RW  = NSLICE * SLICE;
  localparam int PAD = RW - WIDTH;

  logic [RW-1:0] b1Q, b2Q, mQ;
  logic [RW-1:0] s1Q, s2Q;
  logic [RW-1:0] p1, p2, qm;
  logic [RW-1:0] sumAll, carAll;
  logic          aBit, qBit;
  logic [2:0]    chain [NSLICE+1];

  csa_mm_aser #(.WIDTH(WIDTH)) u_aser (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .a1(a1), .a2(a2), .aBit(aBit)
  );

  // parity bit: carries into bit 0 are zero by construction
  assign qBit = s1Q[0] ^ s2Q[0] ^ (aBit & (b1Q[0] ^ b2Q[0]));

  always_comb begin
    p1 = aBit ? b1Q : '0;
    p2 = aBit ? b2Q : '0;
    qm = qBit ? mQ  : '0;
  end

  assign chain[0] = 3'b000;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    csa_mm_slice #(.SW(SLICE)) u_slice (
      .s1  (s1Q[g*SLICE +: SLICE]),
      .s2  (s2Q[g*SLICE +: SLICE]),
      .p1  (p1 [g*SLICE +: SLICE]),
      .p2  (p2 [g*SLICE +: SLICE]),
      .qm  (qm [g*SLICE +: SLICE]),
      .cin (chain[g]),
      .sumV(sumAll[g*SLICE +: SLICE]),
      .carV(carAll[g*SLICE +: SLICE]),
      .cout(chain[g+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      b1Q <= '0;
      b2Q <= '0;
      mQ  <= '0;
      s1Q <= '0;
      s2Q <= '0;
    end else if (strobe.load) begin
      b1Q <= {{PAD{1'b0}}, b1};
      b2Q <= {{PAD{1'b0}}, b2};
      mQ  <= {{PAD{1'b0}}, modulus};
      s1Q <= '0;
      s2Q <= '0;
    end else if (strobe.step) begin
      s1Q <= {1'b0, sumAll[RW-1:1]};
      s2Q <= {1'b0, carAll[RW-1:1]};
    end
  end

  assign sum1 = s1Q[EXT-1:0];
  assign sum2 = s2Q[EXT-1:0];

  // any headroom violation: carry out of top slice, odd bit shifted away,
  // or accumulator bits beyond the exported width
  assign lostBits = (|chain[NSLICE]) | sumAll[0] | carAll[0]
                  | (|s1Q[RW-1:EXT]) | (|s2Q[RW-1:EXT]);

endmodule

// File: rtl/csa_mm_ctrl.sv
// Sequencer: idle until start, then ITERS step cycles, then a done pulse.
module csa_mm_ctrl #(
  parameter int ITERS = 129
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output csa_mm_pkg::mmStrobeT  strobe,
  output logic                  done
);

  localparam int CW = $clog2(ITERS + 1);

  typedef enum logic {ST_IDLE, ST_RUN} stateT;

  stateT         state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == CW'(ITERS - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          iterCnt <= iterCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/csa_mont_mul.sv
// Top: bit-serial Montgomery multiplier with redundant operands and result.
module csa_mont_mul #(
  parameter int WIDTH = 128,
  parameter int SLICE = 64,
  parameter int ITERS = WIDTH + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   a1,
  input  logic [WIDTH-1:0]   a2,
  input  logic [WIDTH-1:0]   b1,
  input  logic [WIDTH-1:0]   b2,
  input  logic [WIDTH-1:0]   modulus,
  output logic               done,
  output logic [WIDTH+1:0]   sum1,
  output logic [WIDTH+1:0]   sum2
);

  localparam int GUARD  = 2;
  localparam int EXT    = WIDTH + GUARD;
  localparam int NSLICE = (EXT + 1 + SLICE - 1) / SLICE;

  csa_mm_pkg::mmStrobeT strobe;
  logic                 lostBits;

  csa_mm_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .done(done)
  );

  csa_mm_dp #(
    .WIDTH(WIDTH), .SLICE(SLICE), .NSLICE(NSLICE), .EXT(EXT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .a1(a1), .a2(a2), .b1(b1), .b2(b2), .modulus(modulus),
    .sum1(sum1), .sum2(sum2), .lostBits(lostBits)
  );

endmodule

// File: rtl/csa_mont_mul_chk.sv
module csa_mont_mul_chk #(
  parameter int EXT = 130
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 done,
  input csa_mm_pkg::mmStrobeT strobe,
  input logic                 lostBits,
  input logic [EXT-1:0]       sum1,
  input logic [EXT-1:0]       sum2
);

  // R1
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (sum1 == '0) && (sum2 == '0));

  // R2
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  done_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strobe.step));

  // R6
  no_load_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.step));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(sum1) && $stable(sum2));

  // R10
  no_headroom_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> !lostBits);

endmodule

bind csa_mont_mul csa_mont_mul_chk #(.EXT(WIDTH + 2)) chk (
  .clk(clk), .rstN(rstN), .done(done), .strobe(strobe),
  .lostBits(lostBits), .sum1(sum1), .sum2(sum2)
);

// File: tb/tb_csa_mont_mul.sv
module tb_csa_mont_mul;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 128;
  localparam int ITERS = W + 1;
  localparam int EXT   = W + 2;
  localparam int BW    = W + 8;
  localparam int XW    = 3 * W + 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   a1 = '0, a2 = '0, b1 = '0, b2 = '0, modulus = '0;
  logic           done;
  logic [EXT-1:0] sum1, sum2;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_mont_mul #(.WIDTH(W), .SLICE(64), .ITERS(ITERS)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .a1(a1), .a2(a2), .b1(b1), .b2(b2), .modulus(modulus),
    .done(done), .sum1(sum1), .sum2(sum2)
  );

  function automatic logic [W-1:0] randW();
    logic [W-1:0] r = '0;
    for (int i = 0; i < (W + 31) / 32; i++) r = (r << 32) | W'($urandom);
    return r;
  endfunction

  function automatic logic [BW-1:0] refSum(input logic [W-1:0] x1, x2, y1, y2, m);
    logic [BW-1:0] a, b, s, t;
    a = BW'(x1) + BW'(x2);
    b = BW'(y1) + BW'(y2);
    s = '0;
    for (int i = 0; i < ITERS; i++) begin
      t = s + (a[i] ? b : '0);
      if (t[0]) t = t + BW'(m);
      s = t >> 1;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] outSum();
    return BW'(sum1) + BW'(sum2);
  endfunction

  task automatic scramble();
    a1 = randW(); a2 = randW(); b1 = randW(); b2 = randW(); modulus = randW();
  endtask

  task automatic runOp(input logic [W-1:0] x1, x2, y1, y2, m,
                       input bit disturb, input bit boundCase);
    logic [BW-1:0] expS, gotS, held1, held2;
    logic [XW-1:0] lhs, rhs, aw, bw;
    int cycles;
    @(negedge clk);
    a1 = x1; a2 = x2; b1 = y1; b2 = y2; modulus = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: accumulator cleared after the sampling edge
    check(sum1 == '0 && sum2 == '0, "R1", outSum(), '0);
    cycles = 0;
    while (!done && cycles < ITERS + 20) begin
      if (disturb) begin
        scramble();                       // R5: inputs change mid-run
        start = (cycles == 3);            // R6: stray start mid-run
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    // R2: latency
    check(cycles == ITERS, "R2", BW'(cycles), BW'(ITERS));
    expS = refSum(x1, x2, y1, y2, m);
    gotS = outSum();
    // R3 / R4 / R5 / R6 / R9: exact recurrence
    check(gotS == expS, disturb ? "R3 R5 R6" : "R3 R4 R9", gotS, expS);
    // R3: Montgomery congruence
    aw  = XW'(x1) + XW'(x2);
    bw  = XW'(y1) + XW'(y2);
    lhs = (XW'(gotS) << ITERS) % XW'(m);
    rhs = (aw * bw) % XW'(m);
    check(lhs == rhs, "R3 congruence", BW'(lhs), BW'(rhs));
    if (boundCase) begin
      // R7: bounded by 2M
      check(gotS < 2 * BW'(m), "R7", gotS, 2 * BW'(m));
    end
    held1 = BW'(sum1);
    held2 = BW'(sum2);
    @(negedge clk);
    // R2: single-cycle pulse
    check(!done, "R2 pulse", BW'(done), '0);
    scramble();
    repeat (3) @(negedge clk);
    // R8: result held while idle
    check(BW'(sum1) == held1 && BW'(sum2) == held2, "R8", BW'(sum1), held1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] ones, m, hb;
    void'($urandom(32'h5eed_1234));
    ones = '1;
    hb   = '0;
    hb[W-1] = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!done && sum1 == '0 && sum2 == '0, "R11 in reset", outSum(), '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && sum1 == '0 && sum2 == '0, "R11 after reset", outSum(), '0);

    // R4: all-ones multiplier halves force the final carry; top-heavy modulus
    runOp(ones, ones, ones, ones, ones, 1'b0, 1'b0);
    runOp(ones, ones, 1, 0, hb | 1, 1'b0, 1'b0);
    // R9: zero multiplier and zero multiplicand
    runOp('0, '0, randW(), randW(), randW() | 1, 1'b0, 1'b0);
    runOp(randW(), randW(), '0, '0, randW() | 1, 1'b0, 1'b0);
    // small modulus
    runOp(randW(), randW(), randW(), randW(), 3, 1'b0, 1'b0);

    for (int n = 0; n < 24; n++) begin
      m = randW() | hb | 1;
      if (n % 3 == 0) begin
        // R7: constrained multiplicand below M
        runOp(randW(), randW(), randW() % (m >> 1), randW() % (m >> 1), m, n % 2 == 1, 1'b1);
      end else begin
        runOp(randW(), randW(), randW(), randW(), m, n % 2 == 1, 1'b0);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule